// File: doc/BRIEF.md
# Odd-Residue Index-Domain Multiplier

This block forms the product of two odd N-bit words modulo 2^N without any partial-product array. Every odd residue modulo 2^N can be written in exactly one way as g^l · 3^m mod 2^N. Here g is a fixed element of order two that is not a power of 3, l is a single bit, and m is an (N-2)-bit exponent. The block converts each operand into its (l, m) index pair through a table match. It adds the two pairs field by field: the l bits modulo 2 and the m fields modulo 2^(N-2), with the two additions side by side. It then maps the summed pair back to an odd word through a second table. Both tables are computed when the design is elaborated, from N and the choice of g. The logic depth is one table match, one short adder and one table read, whatever the value of N. Only the table size grows with N.

Operands enter on a valid/ready stream and the product leaves on another valid/ready stream. There is one register stage after the index conversion and a second after the conversion back to a word. A transfer happens on a rising edge where valid and ready are both high. The output holds its word while it is stalled. The input ready signal falls only when both stages are full and the consumer is not ready, so the pipeline moves one pair per clock when nothing stalls. An even operand cannot be converted: that transfer carries the error flag and its product word has no defined value.

Top module: `odd_logmul`

## Requirements
- R1: For odd operands a and b, the word delivered with the transfer is (a·b) mod 2^N.
- R2: With the pipeline empty and out_ready high, a pair accepted on rising edge T is presented with out_valid high after rising edge T+1, and out_valid stays low between edge T and edge T+1.
- R3: While out_valid is high and out_ready is low, out_valid, out_prod and out_err keep their values on the next edge.
- R4: in_ready is low exactly when both stages hold data and out_ready is low. Results leave in the order their operands were accepted, with none lost or duplicated.
- R5: out_err is 1 for a transfer whose in_a or in_b has bit 0 equal to 0. It is 0 when both operands are odd.
- R6: After reset, out_valid is 0 and in_ready is 1.
- R7: Every delivered word with out_err equal to 0 is odd.
- R8: Parameter X_ALT selects the order-two element: 0 selects 2^N−1, and 1 selects 2^(N−1)−1 (for N=3 it falls back to 2^N−1). The products are the same under either choice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair on this edge |
| in_a | input | N | First operand |
| in_b | input | N | Second operand |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product on this edge |
| out_prod | output | N | Product modulo 2^N |
| out_err | output | 1 | At least one operand of this transfer was even |

## Verification
Every odd pair is checked against a*b mod 2^N for N=4 with the alternate order-two element and for N=6 with 2^N−1. A wrong table entry, a missed wrap of the m field, or a carry leaking from m into l would show up as a wrong product for a small set of pairs. A stall with both stages full checks that in_ready drops, and that the head result neither changes nor gets overtaken or dropped. A design that pulled ready from the wrong stage would lose or duplicate a result. Random traffic with even operands and a toggling consumer checks that the error flag travels with its own transfer and not with its neighbours'.

// File: rtl/oddmul_pkg.sv
package oddmul_pkg;

  // residue of base^e modulo 2^w
  function automatic longint unsigned pow_mod(int unsigned w, longint unsigned base,
                                              int unsigned e);
    longint unsigned mask;
    longint unsigned acc;
    mask = (64'd1 << w) - 64'd1;
    acc  = 64'd1;
    for (int unsigned i = 0; i < e; i++) acc = (acc * base) & mask;
    return acc;
  endfunction

  // element of order two that is not a power of 3
  function automatic longint unsigned order2_elem(int unsigned w, bit alt);
    if (alt && w >= 4) return (64'd1 << (w - 1)) - 64'd1;
    return (64'd1 << w) - 64'd1;
  endfunction

  // odd value represented by index pair (l, m)
  function automatic longint unsigned pair_value(int unsigned w, bit alt,
                                                 int unsigned l, int unsigned m);
    longint unsigned mask;
    longint unsigned v;
    mask = (64'd1 << w) - 64'd1;
    v    = pow_mod(w, 64'd3, m);
    if (l != 0) v = (v * order2_elem(w, alt)) & mask;
    return v;
  endfunction

endpackage

// File: rtl/oddmul_encoder.sv
module oddmul_encoder #(
  parameter int N     = 6,
  parameter bit X_ALT = 1'b0
) (
  input  logic [N-1:0] value,
  output logic         l_idx,
  output logic [N-3:0] m_idx,
  output logic         miss
);
  localparam int M  = N - 2;
  localparam int IW = N - 1;
  localparam int E  = 1 << IW;

  logic [E-1:0]  hit;
  logic [IW-1:0] idx;

  // one comparator per odd residue; index = {l, m}
  for (genvar g = 0; g < E; g++) begin : g_ent
    localparam logic [N-1:0] KVAL =
      N'(oddmul_pkg::pair_value(N, X_ALT, g >> M, g & ((1 << M) - 1)));
    assign hit[g] = (value == KVAL);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < E; i++) begin
      if (hit[i]) idx = idx | IW'(i);
    end
  end

  assign miss  = ~|hit;
  assign l_idx = idx[IW-1];
  assign m_idx = idx[M-1:0];
endmodule

// File: rtl/oddmul_idx_add.sv
module oddmul_idx_add #(
  parameter int M = 4
) (
  input  logic         la,
  input  logic [M-1:0] ma,
  input  logic         lb,
  input  logic [M-1:0] mb,
  output logic         ls,
  output logic [M-1:0] ms
);
  logic [M:0] wide;

  // the two index fields are summed independently
  assign ls   = la ^ lb;
  assign wide = {1'b0, ma} + {1'b0, mb};
  assign ms   = wide[M-1:0];
endmodule

// File: rtl/oddmul_decoder.sv
module oddmul_decoder #(
  parameter int N     = 6,
  parameter bit X_ALT = 1'b0
) (
  input  logic         l_idx,
  input  logic [N-3:0] m_idx,
  output logic [N-1:0] value
);
  localparam int M  = N - 2;
  localparam int IW = N - 1;
  localparam int E  = 1 << IW;

  logic [N-1:0] lut [E];

  for (genvar g = 0; g < E; g++) begin : g_ent
    assign lut[g] = N'(oddmul_pkg::pair_value(N, X_ALT, g >> M, g & ((1 << M) - 1)));
  end

  assign value = lut[{l_idx, m_idx}];
endmodule

// File: rtl/odd_logmul.sv
module odd_logmul #(
  parameter int N     = 6,
  parameter bit X_ALT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_prod,
  output logic         out_err
);
  localparam int M = N - 2;

  // conversion of the incoming operands
  logic         ea_l, eb_l, ea_miss, eb_miss;
  logic [M-1:0] ea_m, eb_m;

  oddmul_encoder #(.N(N), .X_ALT(X_ALT)) u_enc_a (
    .value(in_a), .l_idx(ea_l), .m_idx(ea_m), .miss(ea_miss));
  oddmul_encoder #(.N(N), .X_ALT(X_ALT)) u_enc_b (
    .value(in_b), .l_idx(eb_l), .m_idx(eb_m), .miss(eb_miss));

  // stage 1: index pairs
  logic         s1_valid, s1_err, s1_la, s1_lb;
  logic [M-1:0] s1_ma, s1_mb;
  logic         s1_adv, s2_adv;

  assign s2_adv   = !out_valid || out_ready;
  assign s1_adv   = !s1_valid || s2_adv;
  assign in_ready = s1_adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_err   <= 1'b0;
      s1_la    <= 1'b0;
      s1_lb    <= 1'b0;
      s1_ma    <= '0;
      s1_mb    <= '0;
    end else if (s1_adv) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_err <= ea_miss | eb_miss;
        s1_la  <= ea_l;
        s1_lb  <= eb_l;
        s1_ma  <= ea_m;
        s1_mb  <= eb_m;
      end
    end
  end

  // index addition and conversion back to a word
  logic         sum_l;
  logic [M-1:0] sum_m;
  logic [N-1:0] dec_val;

  oddmul_idx_add #(.M(M)) u_add (
    .la(s1_la), .ma(s1_ma), .lb(s1_lb), .mb(s1_mb), .ls(sum_l), .ms(sum_m));
  oddmul_decoder #(.N(N), .X_ALT(X_ALT)) u_dec (
    .l_idx(sum_l), .m_idx(sum_m), .value(dec_val));

  // stage 2: output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_prod  <= '0;
      out_err   <= 1'b0;
    end else if (s2_adv) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_prod <= dec_val;
        out_err  <= s1_err;
      end
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_prod) && $stable(out_err)); // R3
  AST_READY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |-> !in_ready); // R4
  AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid); // R2
  AST_STAGE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && (!out_valid || out_ready) |=> out_valid); // R2
  AST_ERR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_err == !($past(in_a[0]) && $past(in_b[0]))); // R5
  AST_ODD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_prod[0]); // R7
endmodule

// File: tb/odd_logmul_bench.sv
module odd_logmul_lane #(
  parameter int N     = 4,
  parameter bit X_ALT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   errors,
  output logic done
);
  localparam int MASK = (1 << N) - 1;

  logic         in_valid, in_ready, out_valid, out_err;
  logic         ready_man, rnd_mode, rnd_bit, out_ready;
  logic [N-1:0] in_a, in_b, out_prod;

  int mon_checks = 0, mon_errs = 0, dir_checks = 0, dir_errs = 0;
  logic [N:0] exp_q[$];

  assign out_ready = rnd_mode ? rnd_bit : ready_man;
  assign checks    = mon_checks + dir_checks;
  assign errors    = mon_errs + dir_errs;

  odd_logmul #(.N(N), .X_ALT(X_ALT)) u_odd_logmul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_prod), .out_err(out_err));

  always @(posedge clk) begin
    #1 rnd_bit = ($urandom % 3) != 0;
  end

  // reference scoreboard, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready) begin
        logic [N:0] e;
        if (exp_q.size() == 0) begin
          mon_checks++; mon_errs++;
          $display("FAIL R4 N=%0d unexpected output %0d, expected none", N, out_prod);
        end else begin
          e = exp_q.pop_front();
          mon_checks++;
          if (out_err !== e[N]) begin
            mon_errs++;
            $display("FAIL R5 N=%0d err %0b expected %0b", N, out_err, e[N]);
          end else if (!e[N]) begin
            mon_checks++;
            if (out_prod !== e[N-1:0]) begin
              mon_errs++;
              $display("FAIL R1 R8 N=%0d alt=%0b product %0d expected %0d",
                       N, X_ALT, out_prod, e[N-1:0]);
            end
            mon_checks++;
            if (out_prod[0] !== 1'b1) begin
              mon_errs++;
              $display("FAIL R7 N=%0d product %0d expected odd", N, out_prod);
            end
          end
        end
      end
      if (in_valid && in_ready) begin
        int p;
        p = (int'(in_a) * int'(in_b)) & MASK;
        exp_q.push_back({~(in_a[0] & in_b[0]), N'(p)});
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    dir_checks++;
    if (!ok) begin
      dir_errs++;
      $display("FAIL %s N=%0d actual %0d expected %0d", tag, N, act, exp);
    end
  endtask

  task automatic send(input int a, input int b);
    bit acc;
    in_a = N'(a); in_b = N'(b); in_valid = 1'b1;
    do begin
      @(negedge clk) acc = in_ready;
      @(posedge clk); #1;
    end while (!acc);
    in_valid = 1'b0;
  endtask

  initial begin
    in_valid = 0; in_a = '0; in_b = '0; ready_man = 1; rnd_mode = 0; done = 0;
    rnd_bit = 1;
    wait (rst_n === 1'b1);
    @(posedge clk); #1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R6 in_ready", int'(in_ready), 1);
    chk(out_valid === 1'b0, "R6 out_valid", int'(out_valid), 0);
    @(posedge clk); #1;

    // every odd pair (R1, R8)
    for (int a = 1; a < (1 << N); a += 2)
      for (int b = 1; b < (1 << N); b += 2) send(a, b);
    repeat (4) @(posedge clk); #1;

    // latency from an empty pipeline (R2)
    in_a = N'(3); in_b = N'(5); in_valid = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R2 ready idle", int'(in_ready), 1);
    @(posedge clk); #1 in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R2 early valid", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid === 1'b1, "R2 valid", int'(out_valid), 1);
    chk(out_prod === N'(15 & MASK), "R2 product", int'(out_prod), 15 & MASK);
    repeat (3) @(posedge clk); #1;

    // stall with both stages full (R3, R4)
    ready_man = 0;
    send(7, 9);
    send(11, 13);
    in_a = N'(5); in_b = N'(5); in_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R4 ready full", int'(in_ready), 0);
      chk(out_prod === N'(63 & MASK), "R3 held product", int'(out_prod), 63 & MASK);
      chk(out_valid === 1'b1, "R3 held valid", int'(out_valid), 1);
    end
    @(posedge clk); #1 ready_man = 1;
    in_valid = 1'b0;
    send(5, 5);
    repeat (4) @(posedge clk); #1;

    // mixed traffic with even operands and a toggling consumer (R4, R5)
    rnd_mode = 1;
    for (int k = 0; k < 300; k++) begin
      int a, b;
      a = int'($urandom) & MASK;
      b = int'($urandom) & MASK;
      if (k % 5 == 0) a = a & ~1;
      else if (k % 5 != 3) begin a = a | 1; b = b | 1; end
      send(a, b);
      if (k % 7 == 0) begin @(posedge clk); #1; end
    end
    rnd_mode = 0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0, "R4 drained", exp_q.size(), 0);
    done = 1;
  end
endmodule

module odd_logmul_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c4, e4, c6, e6;
  logic d4, d6;

  always #2.5 clk = ~clk;

  odd_logmul_lane #(.N(4), .X_ALT(1'b1)) u_lane4 (
    .clk(clk), .rst_n(rst_n), .checks(c4), .errors(e4), .done(d4));
  odd_logmul_lane #(.N(6), .X_ALT(1'b0)) u_lane6 (
    .clk(clk), .rst_n(rst_n), .checks(c6), .errors(e6), .done(d6));

  initial begin
    int extra;
    extra = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int c = 0; c < 150000 && !(d4 === 1'b1 && d6 === 1'b1); c++) @(posedge clk);
    if (!(d4 === 1'b1 && d6 === 1'b1)) begin
      extra = 1;
      $display("FAIL R4 watchdog expired: done %0b%0b expected 11", d4, d6);
    end
    $display("CHECKS %0d ERRORS %0d", c4 + c6 + extra, e4 + e6 + extra);
    $finish;
  end
endmodule